// File: doc/BRIEF.md
# Power-Bad and FET-Short Fault Detector

This block watches each channel of a multi-channel hot-plug power switch and turns conditioned monitor inputs into fault and status flags. Each channel has three flags from the analog front end: the gate is being driven on, the gate-to-source voltage is above its threshold, and the feedback comparator reads below its threshold. A current-sense word from a shared data converter arrives with a per-channel valid strobe.

A power-bad condition needs the feedback to stay low for more than a programmable number of clock cycles. This window stands for about 2 µs. The count only runs while the gate-to-source voltage is above threshold, so ramp-up and ramp-down cannot raise a false alarm. When power-bad is declared, a live status flag and a latched fault flag are set, and the open-drain power-good output is told to pull low. A FET-short fault is judged only from converter samples taken while the gate is commanded off. If such a sample reaches the sense threshold, a latched short flag is set. Latched flags are cleared by a per-channel clear pulse. Software writes or card-insertion logic outside this block produce that pulse.

Top module: `hsw_fault_detect`

## Requirements
- R1: After reset every output of every channel is 0.
- R2: A valid current-sense sample (`senseValid`=1) at or above `SENSE_THR` LSBs, taken while `gateOn`=0, sets that channel's `fetShortFault` one clock later.
- R3: A valid sample equal to `SENSE_THR`-1 while the gate is off leaves `fetShortFault` at 0.
- R4: While `gateOn`=1, no sample sets `fetShortFault`, whatever its value.
- R5: A sample presented with `senseValid`=0 has no effect on `fetShortFault`.
- R6: With `gateHigh`=1 and `fbLow`=1 sampled on `PB_CYCLES`+1 consecutive clock edges, `pbStatus`, `pbFault` and `pgPullLow` are all 1 after the last of those edges. After only `PB_CYCLES` such edges, all three are still 0.
- R7: Any edge with `fbLow`=0 or `gateHigh`=0 restarts the qualifying count. With `gateHigh`=0, `fbLow` may stay 1 for any length of time and never sets power-bad.
- R8: One edge with `fbLow`=0 clears `pbStatus` and `pgPullLow`. `pbFault` stays 1.
- R9: A `clearFault` pulse clears `pbFault` and `fetShortFault` on the next edge. A set condition in the same cycle wins over the clear.
- R10: Channels are independent. Activity on one channel never changes another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateOn | input | NCH | Gate drive commanded on, per channel |
| gateHigh | input | NCH | Gate-to-source voltage above threshold, per channel |
| fbLow | input | NCH | Feedback below power-good threshold, per channel |
| senseData | input | NCH*SW | Current-sense samples; channel c occupies bits [c*SW +: SW] |
| senseValid | input | NCH | Sample strobe, per channel |
| clearFault | input | NCH | Clears latched faults, per channel |
| pbStatus | output | NCH | Power-bad present (live) |
| pbFault | output | NCH | Power-bad fault (latched) |
| fetShortFault | output | NCH | FET-short fault (latched) |
| pgPullLow | output | NCH | Enable for the open-drain power-good pull-down |

## Verification
Power-bad is driven with runs of low feedback lasting exactly the window and one cycle longer, which pins the off-by-one of the qualifier. The run is also broken once by a feedback glitch and once by a gate dip, which shows that each of the two restart paths works. Sense samples are applied at the threshold and one code below, with the gate on, and without a strobe. Together these separate the comparison from its gating by gate state and by the strobe. Clears that arrive in the same cycle as a new fault, and activity confined to one channel, show the set-over-clear priority and the channel isolation.

// File: rtl/hsw_fault_pkg.sv
package hsw_fault_pkg;
  typedef struct packed {
    logic pbSet;
    logic pbClr;
    logic fsSet;
  } faultStrb_t;
endpackage

// File: rtl/fault_qual_ctrl.sv
module fault_qual_ctrl
  import hsw_fault_pkg::*;
#(
  parameter int PB_CYCLES = 400,
  parameter int SW        = 12,
  parameter int SENSE_THR = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          gateOn,
  input  logic          gateHigh,
  input  logic          fbLow,
  input  logic [SW-1:0] senseData,
  input  logic          senseValid,
  output faultStrb_t    strb
);
  localparam int CW = $clog2(PB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(PB_CYCLES);
  localparam logic [SW-1:0] THR = SW'(SENSE_THR);

  logic [CW-1:0] qualCnt;
  logic          qualify;

  // Gate must be above threshold and feedback low for the window to count.
  assign qualify = gateHigh & fbLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 qualCnt <= '0;
    else if (!qualify)         qualCnt <= '0;
    else if (qualCnt != CNT_TOP) qualCnt <= qualCnt + 1'b1;
  end

  always_comb begin
    strb.pbSet = qualify && (qualCnt == CNT_TOP);
    strb.pbClr = !fbLow;
    strb.fsSet = senseValid && !gateOn && (senseData >= THR);
  end

  // R6: a power-bad strobe follows a cycle that also qualified
  a_r6_prior_qualify: assert property (@(posedge clk) disable iff (!rstN)
    strb.pbSet |-> $past(qualify));
  // R7: a gate dip blocks a set on the following cycle
  a_r7_gate_block: assert property (@(posedge clk) disable iff (!rstN)
    !gateHigh |=> !strb.pbSet);
endmodule

// File: rtl/fault_flag_regs.sv
module fault_flag_regs
  import hsw_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  faultStrb_t strb,
  input  logic       clearFault,
  output logic       pbStatus,
  output logic       pbFault,
  output logic       fsFault
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pbStatus <= 1'b0;
      pbFault  <= 1'b0;
      fsFault  <= 1'b0;
    end else begin
      if (strb.pbSet)      pbStatus <= 1'b1;
      else if (strb.pbClr) pbStatus <= 1'b0;

      if (strb.pbSet)      pbFault <= 1'b1;
      else if (clearFault) pbFault <= 1'b0;

      if (strb.fsSet)      fsFault <= 1'b1;
      else if (clearFault) fsFault <= 1'b0;
    end
  end

  // R2: short strobe latches the fault
  a_r2_short_latch: assert property (@(posedge clk) disable iff (!rstN)
    strb.fsSet |=> fsFault);
  // R6: status never rises without the latched fault
  a_r6_fault_with_status: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pbStatus) |-> pbFault);
  // R8: feedback recovery drops the live status
  a_r8_recover: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pbClr && !strb.pbSet) |=> !pbStatus);
  // R9: clear without a competing set empties the latches
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clearFault && !strb.fsSet && !strb.pbSet) |=> (!fsFault && !pbFault));
endmodule

// File: rtl/hsw_fault_detect.sv
module hsw_fault_detect
  import hsw_fault_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int SW        = 12,
  parameter int SENSE_THR = 16,
  parameter int PB_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    gateOn,
  input  logic [NCH-1:0]    gateHigh,
  input  logic [NCH-1:0]    fbLow,
  input  logic [NCH*SW-1:0] senseData,
  input  logic [NCH-1:0]    senseValid,
  input  logic [NCH-1:0]    clearFault,
  output logic [NCH-1:0]    pbStatus,
  output logic [NCH-1:0]    pbFault,
  output logic [NCH-1:0]    fetShortFault,
  output logic [NCH-1:0]    pgPullLow
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    faultStrb_t strb;

    fault_qual_ctrl #(
      .PB_CYCLES(PB_CYCLES), .SW(SW), .SENSE_THR(SENSE_THR)
    ) u_ctrl (
      .clk(clk), .rstN(rstN),
      .gateOn(gateOn[c]), .gateHigh(gateHigh[c]), .fbLow(fbLow[c]),
      .senseData(senseData[c*SW +: SW]), .senseValid(senseValid[c]),
      .strb(strb)
    );

    fault_flag_regs u_regs (
      .clk(clk), .rstN(rstN), .strb(strb), .clearFault(clearFault[c]),
      .pbStatus(pbStatus[c]), .pbFault(pbFault[c]), .fsFault(fetShortFault[c])
    );
  end

  // The pull-down follows the live power-bad status.
  assign pgPullLow = pbStatus;

  // R1: nothing is flagged in the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> (pbStatus == '0 && pbFault == '0 && fetShortFault == '0));
endmodule

// File: tb/sim_hsw_fault_detect.sv
module sim_hsw_fault_detect;
  localparam int NCH = 2, SW = 12, THR = 16, PB = 400;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NCH-1:0] gateOn = '0, gateHigh = '0, fbLow = '0, senseValid = '0, clearFault = '0;
  logic [NCH*SW-1:0] senseData = '0;
  logic [NCH-1:0] pbStatus, pbFault, fetShortFault, pgPullLow;
  int nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  hsw_fault_detect #(.NCH(NCH), .SW(SW), .SENSE_THR(THR), .PB_CYCLES(PB)) u0 (.*);

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clearAll();
    fbLow = '0; gateHigh = '0; gateOn = '0; senseValid = '0;
    clearFault = '1; step(); clearFault = '0; step();
  endtask

  task automatic t_reset();
    chk("R1 pbStatus", |pbStatus, 1'b0);
    chk("R1 pbFault", |pbFault, 1'b0);
    chk("R1 fetShort", |fetShortFault, 1'b0);
    chk("R1 pgPullLow", |pgPullLow, 1'b0);
  endtask

  task automatic t_fetShort();
    gateOn = 2'b00; senseData[SW-1:0] = SW'(THR - 1); senseValid[0] = 1'b1; step();
    senseValid = '0; step();
    chk("R3 below threshold", fetShortFault[0], 1'b0);
    senseData[SW-1:0] = SW'(4000); step();
    chk("R5 no strobe", fetShortFault[0], 1'b0);
    gateOn[0] = 1'b1; senseValid[0] = 1'b1; step();
    senseValid = '0; step();
    chk("R4 gate on", fetShortFault[0], 1'b0);
    gateOn[0] = 1'b0; senseData[SW-1:0] = SW'(THR); senseValid[0] = 1'b1; step();
    senseValid = '0;
    chk("R2 at threshold", fetShortFault[0], 1'b1);
    chk("R10 other channel", fetShortFault[1], 1'b0);
    clearFault[0] = 1'b1; step(); clearFault = '0;
    chk("R9 clear short", fetShortFault[0], 1'b0);
    clearFault[0] = 1'b1; senseValid[0] = 1'b1; step();
    clearFault = '0; senseValid = '0;
    chk("R9 set wins", fetShortFault[0], 1'b1);
    clearAll();
  endtask

  task automatic t_powerBad();
    gateHigh[0] = 1'b1; fbLow[0] = 1'b1; step(PB);
    chk("R6 window only", pbStatus[0], 1'b0);
    chk("R6 window only fault", pbFault[0], 1'b0);
    step();
    chk("R6 status", pbStatus[0], 1'b1);
    chk("R6 fault", pbFault[0], 1'b1);
    chk("R6 pull low", pgPullLow[0], 1'b1);
    chk("R10 ch1 status", pbStatus[1], 1'b0);
    fbLow[0] = 1'b0; step();
    chk("R8 status clears", pbStatus[0], 1'b0);
    chk("R8 pull releases", pgPullLow[0], 1'b0);
    chk("R8 fault held", pbFault[0], 1'b1);
    clearFault[0] = 1'b1; step(); clearFault = '0;
    chk("R9 clear pb", pbFault[0], 1'b0);
    clearAll();
  endtask

  task automatic t_restart();
    gateHigh[1] = 1'b1; fbLow[1] = 1'b1; step(PB);
    fbLow[1] = 1'b0; step(); fbLow[1] = 1'b1; step(PB);
    chk("R7 fb glitch restarts", pbStatus[1], 1'b0);
    gateHigh[1] = 1'b0; step(); gateHigh[1] = 1'b1; step(PB);
    chk("R7 gate dip restarts", pbStatus[1], 1'b0);
    step();
    chk("R7 full window after dip", pbStatus[1], 1'b1);
    chk("R10 ch0 untouched", pbFault[0], 1'b0);
    clearAll();
    gateHigh = '0; fbLow = '1; step(PB + 20);
    chk("R7 gate low blocks", |pbStatus, 1'b0);
    chk("R7 gate low no fault", |pbFault, 1'b0);
    clearAll();
  endtask

  initial begin
    step(2);
    t_reset();
    rstN = 1'b1; step();
    t_reset();
    t_fetShort();
    t_powerBad();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #1ms;
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule